// File: doc/BRIEF.md
# Manchester Frame Transmitter with Block Check Fields

This block turns one frame, held as 16-bit words in an external transmit buffer, into a serial Manchester-coded line. A send request carries a frame type (master or slave) and a length code. When the block accepts the request, it emits a start delimiter of eighteen half-bit levels for the chosen type, then the data bits, then the end mark. A check field follows every 64 data bits, and one more follows the final data bit when the frame length is not a multiple of 64. The end mark is a single all-low cell, after which the line goes back to its idle high level.

The whole schedule advances on a half-cell enable, which pulses at twice the bit rate: 3 MHz for a 1.5 Mbit/s line. The transmitter reads the buffer through a combinational word port, which it addresses itself. A configuration input gates whether requests may start a frame. While a frame is running the block shows busy. When the line returns to idle it pulses done for one cycle.

Top module: `mfx_tx`

## Requirements
- R1: Each data bit occupies two half-cells. A 1 is sent high then low, and a 0 is sent low then high. The level changes only on a clock where `half_en` is high.
- R2: The first 18 half-cells of a frame are the levels of `master_delim` (when `frm_slave`=0) or `slave_delim` (when `frm_slave`=1), latched at acceptance and sent from bit 17 down to bit 0.
- R3: `len_code` values 0, 1, 2, 3 and 4 select 16, 32, 64, 128 and 256 data bits. Data is taken from buffer word 0 upward (`buf_addr`), and each word is sent most significant bit first.
- R4: A check field of 8 bits follows each full block of 64 data bits, and follows the last data bit when that bit does not close a block. The field holds the 7-bit remainder of an LFSR over the block's bits, using generator x^7+x^6+x^5+x^2+1 and cleared at the start of each block, sent MSB first. It ends with an even-parity bit over the block's data bits and those 7 bits. The field is Manchester coded.
- R5: After the last check field the line is low for two half-cells (one NL cell). It returns high at the next half-cell enable.
- R6: `done` is high for exactly one clock, on the clock where the line returns to idle. `busy` falls on that same clock.
- R7: A request is accepted only when the block is idle, `tx_allow` is high and `len_code` is at most 4. `busy` rises on the clock after acceptance.
- R8: `send_req` while busy is ignored. The running frame continues unchanged and no second frame follows.
- R9: A request with `tx_allow` low, or with `len_code` above 4, is ignored. `busy` stays low and the line stays high.
- R10: After reset and whenever idle, `line_out` is high, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_en | input | 1 | One-cycle pulse per half-cell period |
| tx_allow | input | 1 | Configuration permits transmission |
| send_req | input | 1 | Send strobe |
| frm_slave | input | 1 | Frame type: 0 master, 1 slave |
| len_code | input | 3 | Data length code (0..4 = 16..256 bits) |
| master_delim | input | 18 | Half-cell levels of the master start delimiter |
| slave_delim | input | 18 | Half-cell levels of the slave start delimiter |
| buf_addr | output | 4 | Word address into the transmit buffer |
| buf_data | input | 16 | Word read from the transmit buffer |
| line_out | output | 1 | Manchester-coded line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The frame path is exercised with lengths 16 and 32, which are shorter than a block and get one trailing check field. Length 64 ends exactly on a block boundary, so a doubled check field would be caught. Lengths 128 and 256 have several blocks, which shows whether the LFSR and parity clear between blocks. The buffer is filled with all-ones, all-zeros, alternating and counting patterns. These separate errors in the Manchester polarity, the bit order within a word, the word order and the parity sense. Master and slave frames use distinct asymmetric delimiter patterns, so a wrong pattern choice or a reversed pattern order shows up. Requests sent during a frame, with configuration blocked, or with out-of-range length codes must leave the line and status as the reference model predicts.

// File: rtl/mfx_pkg.sv
package mfx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELIM,
        ST_DATA,
        ST_CHECK,
        ST_END,
        ST_TAIL
    } tx_state_t;

    typedef enum logic {
        SYM_RAW,
        SYM_DATA
    } sym_kind_t;

    typedef struct packed {
        sym_kind_t kind;
        logic      lvl;
    } sym_t;

    localparam int        CRC_W    = 7;
    localparam logic [6:0] CRC_POLY = 7'h65;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic d);
        logic fb;
        fb = c[CRC_W-1] ^ d;
        crc_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/mfx_crc7.sv
module mfx_crc7
    import mfx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             shift,
    input  logic             din,
    output logic [CRC_W-1:0] crc_q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            crc_q <= '0;
        else if (shift)
            crc_q <= crc_step(crc_q, din);
    end
endmodule

// File: rtl/mfx_word_shift.sv
module mfx_word_shift #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] buf_data,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              cur_bit
);
    logic [WORD_W-1:0] sreg_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            addr_q <= '0;
        end else if (start) begin
            addr_q <= '0;
        end else if (load) begin
            sreg_q <= buf_data;
            addr_q <= addr_q + 1'b1;
        end else if (shift) begin
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
        end
    end

    assign buf_addr = addr_q;
    assign cur_bit  = sreg_q[WORD_W-1];
endmodule

// File: rtl/mfx_manch_sym.sv
module mfx_manch_sym
    import mfx_pkg::*;
(
    input  sym_t sym,
    input  logic second_half,
    output logic level
);
    always_comb begin
        if (sym.kind == SYM_DATA)
            level = sym.lvl ^ second_half;
        else
            level = sym.lvl;
    end
endmodule

// File: rtl/mfx_tx.sv
module mfx_tx
    import mfx_pkg::*;
#(
    parameter int WORD_W       = 16,
    parameter int MIN_BITS     = 16,
    parameter int MAX_BITS     = 256,
    parameter int BLK_BITS     = 64,
    parameter int DELIM_HALVES = 18,
    localparam int ADDR_W      = $clog2(MAX_BITS / WORD_W),
    localparam int LEN_W       = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    half_en,
    input  logic                    tx_allow,
    input  logic                    send_req,
    input  logic                    frm_slave,
    input  logic [LEN_W-1:0]        len_code,
    input  logic [DELIM_HALVES-1:0] master_delim,
    input  logic [DELIM_HALVES-1:0] slave_delim,
    output logic [ADDR_W-1:0]       buf_addr,
    input  logic [WORD_W-1:0]       buf_data,
    output logic                    line_out,
    output logic                    busy,
    output logic                    done
);
    localparam int CNT_W     = $clog2(MAX_BITS + 1);
    localparam int BLK_W     = $clog2(BLK_BITS);
    localparam int SH_W      = $clog2(WORD_W);
    localparam int DC_W      = $clog2(DELIM_HALVES);
    localparam int CHK_W     = $clog2(CRC_W + 1);
    localparam int LEN_CODES = $clog2(MAX_BITS / MIN_BITS) + 1;

    tx_state_t             state_q;
    logic [DC_W-1:0]       dcnt_q;
    logic                  half_q;
    logic [CNT_W-1:0]      bits_q;
    logic [CNT_W-1:0]      len_bits_q;
    logic [BLK_W-1:0]      blk_q;
    logic [CHK_W-1:0]      chk_q;
    logic [DELIM_HALVES-1:0] delim_q;
    logic                  par_q;
    logic                  line_q;
    logic                  done_q;

    logic                  accept, step, data_end, word_end, frame_last, blk_last;
    logic                  delim_end, chk_end, crc_clr, ld_word, cur_bit;
    logic [CRC_W-1:0]      crc_q;
    logic [CRC_W:0]        chk_byte;
    sym_t                  sym;
    logic                  sym_level;

    assign accept     = (state_q == ST_IDLE) && send_req && tx_allow
                        && (int'(len_code) < LEN_CODES);
    assign step       = half_en && (state_q != ST_IDLE);
    assign data_end   = step && (state_q == ST_DATA) && half_q;
    assign word_end   = (bits_q[SH_W-1:0] == SH_W'(WORD_W - 1));
    assign frame_last = (bits_q == len_bits_q - 1'b1);
    assign blk_last   = (blk_q == BLK_W'(BLK_BITS - 1));
    assign delim_end  = step && (state_q == ST_DELIM) && (dcnt_q == DC_W'(DELIM_HALVES - 1));
    assign chk_end    = step && (state_q == ST_CHECK) && half_q && (chk_q == CHK_W'(CRC_W));
    assign crc_clr    = accept || chk_end;
    assign ld_word    = delim_end || (data_end && word_end && !frame_last);
    assign chk_byte   = {crc_q, par_q ^ (^crc_q)};

    mfx_crc7 u_crc (
        .clk   (clk),
        .rst   (rst),
        .clr   (crc_clr),
        .shift (data_end),
        .din   (cur_bit),
        .crc_q (crc_q)
    );

    mfx_word_shift #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .load     (ld_word),
        .shift    (data_end),
        .buf_data (buf_data),
        .buf_addr (buf_addr),
        .cur_bit  (cur_bit)
    );

    always_comb begin
        sym = '{kind: SYM_RAW, lvl: 1'b1};
        case (state_q)
            ST_DELIM: sym = '{kind: SYM_RAW,  lvl: delim_q[DELIM_HALVES-1]};
            ST_DATA:  sym = '{kind: SYM_DATA, lvl: cur_bit};
            ST_CHECK: sym = '{kind: SYM_DATA, lvl: chk_byte[CHK_W'(CRC_W) - chk_q]};
            ST_END:   sym = '{kind: SYM_RAW,  lvl: 1'b0};
            default:  sym = '{kind: SYM_RAW,  lvl: 1'b1};
        endcase
    end

    mfx_manch_sym u_sym (
        .sym         (sym),
        .second_half (half_q),
        .level       (sym_level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            dcnt_q     <= '0;
            half_q     <= 1'b0;
            bits_q     <= '0;
            len_bits_q <= '0;
            blk_q      <= '0;
            chk_q      <= '0;
            delim_q    <= '0;
            par_q      <= 1'b0;
            line_q     <= 1'b1;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q    <= ST_DELIM;
                dcnt_q     <= '0;
                half_q     <= 1'b0;
                bits_q     <= '0;
                blk_q      <= '0;
                chk_q      <= '0;
                par_q      <= 1'b0;
                len_bits_q <= CNT_W'(MIN_BITS) << len_code;
                delim_q    <= frm_slave ? slave_delim : master_delim;
            end else if (step) begin
                line_q <= sym_level;
                case (state_q)
                    ST_DELIM: begin
                        delim_q <= {delim_q[DELIM_HALVES-2:0], 1'b0};
                        dcnt_q  <= dcnt_q + 1'b1;
                        if (delim_end)
                            state_q <= ST_DATA;
                    end
                    ST_DATA: begin
                        half_q <= ~half_q;
                        if (half_q) begin
                            par_q  <= par_q ^ cur_bit;
                            bits_q <= bits_q + 1'b1;
                            blk_q  <= blk_q + 1'b1;
                            if (frame_last || blk_last) begin
                                state_q <= ST_CHECK;
                                blk_q   <= '0;
                                chk_q   <= '0;
                            end
                        end
                    end
                    ST_CHECK: begin
                        half_q <= ~half_q;
                        if (half_q) begin
                            chk_q <= chk_q + 1'b1;
                            if (chk_end) begin
                                par_q   <= 1'b0;
                                state_q <= (bits_q == len_bits_q) ? ST_END : ST_DATA;
                            end
                        end
                    end
                    ST_END: begin
                        half_q <= ~half_q;
                        if (half_q)
                            state_q <= ST_TAIL;
                    end
                    ST_TAIL: begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign line_out = line_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
endmodule

// File: rtl/mfx_tx_chk.sv
module mfx_tx_chk #(
    parameter int LEN_W     = 3,
    parameter int LEN_CODES = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             half_en,
    input logic             tx_allow,
    input logic             send_req,
    input logic [LEN_W-1:0] len_code,
    input logic             line_out,
    input logic             busy,
    input logic             done
);
    // R1: the line moves only on a half-cell enable
    p_line_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
        !half_en |=> $stable(line_out));

    // R6: done lasts one clock
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: busy falls exactly with done
    p_done_with_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7: a valid request while idle starts a frame
    p_start_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && send_req && tx_allow && (int'(len_code) < LEN_CODES)) |=> busy);

    // R8: once running, a frame ends only through done
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    // R9: blocked or out-of-range requests do not start a frame
    p_no_start_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && (!tx_allow || (int'(len_code) >= LEN_CODES))) |=> !busy);

    // R10: idle line is high
    p_idle_high_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> line_out);
endmodule

bind mfx_tx mfx_tx_chk #(.LEN_W(3), .LEN_CODES(5)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .half_en  (half_en),
    .tx_allow (tx_allow),
    .send_req (send_req),
    .len_code (len_code),
    .line_out (line_out),
    .busy     (busy),
    .done     (done)
);

// File: tb/mfx_tx_bench.sv
module mfx_tx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        half_en = 1'b0;
    logic        tx_allow = 1'b1;
    logic        send_req = 1'b0;
    logic        frm_slave = 1'b0;
    logic [2:0]  len_code = 3'd0;
    logic [17:0] master_delim = 18'b11_1100_0111_0001_0100;
    logic [17:0] slave_delim  = 18'b00_0011_1011_0110_1001;
    logic [3:0]  buf_addr;
    logic [15:0] buf_data;
    logic        line_out, busy, done;

    logic [15:0] mem [16];
    assign buf_data = mem[buf_addr];

    always #2.5 clk = ~clk;

    mfx_tx u_mfx_tx (
        .clk          (clk),
        .rst          (rst),
        .half_en      (half_en),
        .tx_allow     (tx_allow),
        .send_req     (send_req),
        .frm_slave    (frm_slave),
        .len_code     (len_code),
        .master_delim (master_delim),
        .slave_delim  (slave_delim),
        .buf_addr     (buf_addr),
        .buf_data     (buf_data),
        .line_out     (line_out),
        .busy         (busy),
        .done         (done)
    );

    int n_run = 0;
    int n_fail = 0;
    string ctx = "R10";

    // half-cell enable: one pulse every four clocks
    int hcnt = 0;
    always @(negedge clk) begin
        hcnt = (hcnt + 1) % 4;
        half_en = (hcnt == 0);
    end

    // reference model
    bit    q_lvl[$];
    string q_tag[$];
    logic  exp_line = 1'b1, exp_busy = 1'b0, exp_done = 1'b0;
    string cur_tag = "R10";

    task automatic push_manch(input bit b, input string tag);
        q_lvl.push_back(b);   q_tag.push_back(tag);
        q_lvl.push_back(!b);  q_tag.push_back(tag);
    endtask

    task automatic build_frame(input bit slv, input int lc);
        logic [17:0] pat;
        int nbits;
        logic [6:0] crc;
        bit par, b, fb;
        int inblk;
        pat = slv ? slave_delim : master_delim;
        for (int i = 17; i >= 0; i--) begin
            q_lvl.push_back(pat[i]); q_tag.push_back("R2");
        end
        nbits = 16 << lc;
        crc = 0; par = 0; inblk = 0;
        for (int i = 0; i < nbits; i++) begin
            b = mem[i / 16][15 - (i % 16)];
            push_manch(b, (i % 16 == 0) ? "R3" : "R1");
            fb = crc[6] ^ b;
            crc = {crc[5:0], 1'b0};
            if (fb) crc = crc ^ 7'b1100101;
            par = par ^ b;
            inblk++;
            if (inblk == 64 || i == nbits - 1) begin
                for (int k = 6; k >= 0; k--) push_manch(crc[k], "R4");
                push_manch(par ^ (^crc), "R4");
                crc = 0; par = 0; inblk = 0;
            end
        end
        for (int k = 0; k < 2; k++) begin
            q_lvl.push_back(1'b0); q_tag.push_back("R5");
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            q_lvl.delete(); q_tag.delete();
            exp_line = 1'b1; exp_busy = 1'b0; exp_done = 1'b0; cur_tag = "R10";
        end else begin
            exp_done = 1'b0;
            if (half_en && exp_busy) begin
                if (q_lvl.size() > 0) begin
                    exp_line = q_lvl.pop_front();
                    cur_tag  = q_tag.pop_front();
                end else begin
                    exp_line = 1'b1; exp_busy = 1'b0; exp_done = 1'b1; cur_tag = "R5";
                end
            end else if (!exp_busy) begin
                cur_tag = "R10";
            end
            if (!exp_busy && !exp_done && send_req && tx_allow && len_code <= 3'd4) begin
                build_frame(frm_slave, int'(len_code));
                exp_busy = 1'b1;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            n_run++;
            if (line_out !== exp_line) begin
                n_fail++;
                $display("FAIL %s/%s line_out got %b expected %b at %0t", cur_tag, ctx, line_out, exp_line, $time);
            end
            n_run++;
            if (busy !== exp_busy) begin
                n_fail++;
                $display("FAIL R7/%s busy got %b expected %b at %0t", ctx, busy, exp_busy, $time);
            end
            n_run++;
            if (done !== exp_done) begin
                n_fail++;
                $display("FAIL R6/%s done got %b expected %b at %0t", ctx, done, exp_done, $time);
            end
        end
    end

    task automatic pulse_req(input bit slv, input logic [2:0] lc);
        @(negedge clk);
        frm_slave = slv; len_code = lc; send_req = 1'b1;
        @(negedge clk);
        send_req = 1'b0;
    endtask

    task automatic run_frame(input bit slv, input logic [2:0] lc, input string tag);
        ctx = tag;
        pulse_req(slv, lc);
        while (exp_busy) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic fill(input int kind);
        for (int w = 0; w < 16; w++) begin
            case (kind)
                0: mem[w] = 16'hFFFF;
                1: mem[w] = 16'h0000;
                2: mem[w] = 16'hA5C3 ^ 16'(w * 16'h1111);
                default: mem[w] = 16'(w * 16'h0F13 + 16'h8001);
            endcase
        end
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, run did not complete");
        finish_run();
    end

    initial begin
        fill(3);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        n_run++;
        if (line_out !== 1'b1 || busy !== 1'b0 || done !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset state got line=%b busy=%b done=%b expected 1 0 0", line_out, busy, done);
        end

        run_frame(1'b0, 3'd0, "R3");   // 16 bits master
        fill(2);
        run_frame(1'b1, 3'd1, "R2");   // 32 bits slave
        fill(0);
        run_frame(1'b0, 3'd2, "R4");   // exact block boundary
        fill(1);
        run_frame(1'b1, 3'd3, "R4");   // two blocks, zeros
        fill(3);
        run_frame(1'b0, 3'd4, "R4");   // four blocks
        fill(2);
        run_frame(1'b1, 3'd4, "R1");

        // R8: requests while busy are ignored
        ctx = "R8";
        fill(3);
        pulse_req(1'b0, 3'd1);
        repeat (120) @(negedge clk);
        pulse_req(1'b1, 3'd4);
        repeat (30) @(negedge clk);
        pulse_req(1'b0, 3'd0);
        while (exp_busy) @(negedge clk);
        repeat (20) @(negedge clk);

        // R9: blocked and invalid requests
        ctx = "R9";
        tx_allow = 1'b0;
        pulse_req(1'b0, 3'd0);
        repeat (20) @(negedge clk);
        tx_allow = 1'b1;
        pulse_req(1'b0, 3'd5);
        repeat (20) @(negedge clk);
        pulse_req(1'b1, 3'd7);
        repeat (20) @(negedge clk);
        n_run++;
        if (busy !== 1'b0 || line_out !== 1'b1) begin
            n_fail++;
            $display("FAIL R9 ignored request got busy=%b line=%b expected 0 1", busy, line_out);
        end

        // R7: valid request right after a blocked one still starts
        run_frame(1'b1, 3'd0, "R7");
        finish_run();
    end
endmodule